// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block runs the memory side of a load-multiple or store-multiple instruction. When it accepts a start strobe it takes a 16-bit register list, the pre, up, S, writeback and load flags, and the base register value. It then issues one word access per selected register on a request/acknowledge memory port. For loads it writes each returned word to a register-file port. For stores it forwards the register-file read data to the memory port.

The start address, the number of selected registers and the written-back base value are all worked out in the cycle the strobe is accepted. Registers are visited in ascending index order at ascending word addresses. In the completion cycle the block presents the new base value and a request to copy the saved status word into the current status word. During every transfer it marks whether the user register bank is to be used.

The state machine has four states. IDLE waits for a start. XFER holds a request until it is acknowledged. TAIL is the idle cycle after the last load beat. FIN is the one-cycle completion. The transitions are:
- IDLE→XFER on a start with a non-empty list.
- IDLE→FIN on a start with an empty list.
- XFER→XFER on an acknowledge that leaves bits to transfer, or on a wait cycle.
- XFER→TAIL on the last acknowledge of a load.
- XFER→FIN on the last acknowledge of a store.
- TAIL→FIN always.
- FIN→IDLE always.

Top module: `blk_xfer_seq`

## Requirements
- R1: The first address depends on the pre and up flags, with n the count of set list bits. pre=0, up=1 starts at base. pre=1, up=1 starts at base+4. pre=1, up=0 starts at base−4n. pre=0, up=0 starts at base−4n+4.
- R2: Set list bits are served from index 0 upward, and each later access uses the previous address plus 4.
- R3: Exactly one memory access is made per set list bit.
- R4: In the completion cycle `base_wb_we_o` equals the writeback flag. `base_wb_o` is base+4n when up=1 and base−4n when up=0, both from the original base.
- R5: `rf_user_bank_o` is high on every transfer when S=1 and the operation is a store, or when S=1 and the operation is a load whose list excludes bit 15. Otherwise it is low.
- R6: `psr_restore_o` pulses in the completion cycle only when S=1, load=1, bit 15 of the list is set and `can_restore_i` was high at start.
- R7: For a load, `done_o` rises two cycles after the cycle of the last acknowledge. For a store, it rises one cycle after.
- R8: `mem_seq_o` is low on the first access and high on every later access of the same operation.
- R9: An empty list makes no memory request and raises `done_o` in the cycle after the start.
- R10: `busy_o` is high from the cycle after the start through the `done_o` cycle and low after it. A start while busy is ignored.
- R11: A request holds its address and index stable until it is acknowledged.
- R12: During a load acknowledge, `rf_we_o` is high and `rf_wdata_o` equals `mem_rdata_i`. During a store, `mem_wdata_o` equals `rf_rdata_i` for the index shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted in IDLE |
| list_i | input | 16 | Register selection list |
| pre_i | input | 1 | Pre-index flag |
| up_i | input | 1 | Ascending-base flag |
| s_bit_i | input | 1 | S flag |
| wb_i | input | 1 | Writeback flag |
| load_i | input | 1 | 1 = load, 0 = store |
| can_restore_i | input | 1 | Current mode is neither user nor system |
| base_i | input | 32 | Base register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory word address |
| mem_seq_o | output | 1 | Sequential-access marker |
| mem_wdata_o | output | 32 | Store data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Load data |
| rf_idx_o | output | 4 | Register index of the current beat |
| rf_rdata_i | input | 32 | Register-file read data for `rf_idx_o` |
| rf_we_o | output | 1 | Register-file write |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_user_bank_o | output | 1 | Use user-bank registers |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| base_wb_we_o | output | 1 | Base writeback enable |
| base_wb_o | output | 32 | New base value |
| psr_restore_o | output | 1 | Copy saved status to current status |

## Verification
The cycle-level assertions cover a request waiting for an acknowledge, the +4 address step and rising register index between beats, and the non-sequential first access. They also cover register-file writes only on acknowledged load beats and the confinement of writeback and status restore to the completion cycle. Only the bench scenarios show the start address for each of the four modes, the beat count matching the list population, the written-back base and the gap before completion. The same holds for the decision between user bank and status restore, the empty-list path, and start strobes ignored while busy. Those scenarios compare every address, index and data word against a behavioural memory and register array.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2,
        ST_FIN  = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/blk_pop_count.sv
module blk_pop_count #(
    parameter int NREG    = 16,
    parameter int COUNT_W = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0]    vec_i,
    output logic [COUNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < NREG; i++) begin
            count_o = count_o + COUNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/blk_lowest_pick.sv
module blk_lowest_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [NREG-1:0]  onehot_o
);
    // lowest set bit isolated by two's complement
    assign onehot_o = vec_i & (~vec_i + NREG'(1));

    always_comb begin
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/blk_addr_plan.sv
module blk_addr_plan #(
    parameter int ADDR_W     = 32,
    parameter int COUNT_W    = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic               pre_i,
    input  logic               up_i,
    output logic [ADDR_W-1:0]  first_addr_o,
    output logic [ADDR_W-1:0]  new_base_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_end;

    assign span    = ADDR_W'(count_i) * STEP;
    assign low_end = base_i - span;

    always_comb begin
        unique case ({pre_i, up_i})
            2'b01:   first_addr_o = base_i;
            2'b11:   first_addr_o = base_i + STEP;
            2'b10:   first_addr_o = low_end;
            default: first_addr_o = low_end + STEP;
        endcase
        new_base_o = up_i ? (base_i + span) : low_end;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int COUNT_W   = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NREG-1:0]   list_i,
    input  logic              pre_i,
    input  logic              up_i,
    input  logic              s_bit_i,
    input  logic              wb_i,
    input  logic              load_i,
    input  logic              can_restore_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_seq_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [IDX_W-1:0]  rf_idx_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_we_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_user_bank_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              base_wb_we_o,
    output logic [ADDR_W-1:0] base_wb_o,
    output logic              psr_restore_o
);
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_BYTES);
    localparam int                TOP_IX = NREG - 1;

    xfer_state_e state_q, state_d;

    logic [NREG-1:0]    left_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  wbval_q;
    logic               load_q, wb_q, user_q, restore_q, first_q;

    logic [COUNT_W-1:0] sel_count;
    logic [ADDR_W-1:0]  plan_first, plan_base;
    logic [IDX_W-1:0]   pick_idx;
    logic [NREG-1:0]    pick_hot;
    logic               accept, beat_done, last_beat;

    blk_pop_count #(.NREG(NREG), .COUNT_W(COUNT_W)) u_pop (
        .vec_i   (list_i),
        .count_o (sel_count)
    );

    blk_addr_plan #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i       (base_i),
        .count_i      (sel_count),
        .pre_i        (pre_i),
        .up_i         (up_i),
        .first_addr_o (plan_first),
        .new_base_o   (plan_base)
    );

    blk_lowest_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .vec_i    (left_q),
        .idx_o    (pick_idx),
        .onehot_o (pick_hot)
    );

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign beat_done = (state_q == ST_XFER) && mem_ack_i;
    assign last_beat = ((left_q & ~pick_hot) == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (list_i == '0) ? ST_FIN : ST_XFER;
            ST_XFER: if (mem_ack_i && last_beat) state_d = load_q ? ST_TAIL : ST_FIN;
            ST_TAIL: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q    <= '0;
            addr_q    <= '0;
            wbval_q   <= '0;
            load_q    <= 1'b0;
            wb_q      <= 1'b0;
            user_q    <= 1'b0;
            restore_q <= 1'b0;
            first_q   <= 1'b0;
        end else if (accept) begin
            left_q    <= list_i;
            addr_q    <= plan_first;
            wbval_q   <= plan_base;
            load_q    <= load_i;
            wb_q      <= wb_i;
            user_q    <= s_bit_i && (!load_i || !list_i[TOP_IX]);
            restore_q <= s_bit_i && load_i && list_i[TOP_IX] && can_restore_i;
            first_q   <= 1'b1;
        end else if (beat_done) begin
            left_q    <= left_q & ~pick_hot;
            addr_q    <= addr_q + STEP;
            first_q   <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy_o         = (state_q != ST_IDLE);
        mem_req_o      = (state_q == ST_XFER);
        mem_we_o       = mem_req_o && !load_q;
        mem_addr_o     = addr_q;
        mem_seq_o      = mem_req_o && !first_q;
        mem_wdata_o    = rf_rdata_i;
        rf_idx_o       = pick_idx;
        rf_we_o        = mem_req_o && load_q && mem_ack_i;
        rf_wdata_o     = mem_rdata_i;
        rf_user_bank_o = mem_req_o && user_q;
        done_o         = (state_q == ST_FIN);
        base_wb_we_o   = done_o && wb_q;
        base_wb_o      = wbval_q;
        psr_restore_o  = done_o && restore_q;
    end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_ack_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_seq_o,
    input logic [IDX_W-1:0]  rf_idx_o,
    input logic              rf_we_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              base_wb_we_o,
    input logic              psr_restore_o
);
    p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(rf_idx_o)));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

    p_idx_rising_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || rf_idx_o > $past(rf_idx_o)));

    p_first_nonseq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> !mem_seq_o);

    p_later_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_seq_o));

    p_rf_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && mem_ack_i && !mem_we_o));

    p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o ##1 !busy_o);

    p_wb_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_we_o |-> done_o);

    p_restore_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore_o |-> (done_o && !mem_req_o));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_ack_i     (mem_ack_i),
    .mem_addr_o    (mem_addr_o),
    .mem_seq_o     (mem_seq_o),
    .rf_idx_o      (rf_idx_o),
    .rf_we_o       (rf_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .base_wb_we_o  (base_wb_we_o),
    .psr_restore_o (psr_restore_o)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] list_i = '0;
    logic        pre_i = 1'b0, up_i = 1'b0, s_bit_i = 1'b0, wb_i = 1'b0;
    logic        load_i = 1'b0, can_restore_i = 1'b0;
    logic [31:0] base_i = '0;
    logic        mem_req_o, mem_we_o, mem_seq_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [3:0]  rf_idx_o;
    logic [31:0] rf_rdata_i;
    logic        rf_we_o;
    logic [31:0] rf_wdata_o;
    logic        rf_user_bank_o, busy_o, done_o, base_wb_we_o, psr_restore_o;
    logic [31:0] base_wb_o;

    logic [31:0] regs [16];
    logic [31:0] mem  [256];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign rf_rdata_i = regs[rf_idx_o];

    blk_xfer_seq u_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i),
        .pre_i(pre_i), .up_i(up_i), .s_bit_i(s_bit_i), .wb_i(wb_i),
        .load_i(load_i), .can_restore_i(can_restore_i), .base_i(base_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_seq_o(mem_seq_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .rf_idx_o(rf_idx_o), .rf_rdata_i(rf_rdata_i),
        .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .rf_user_bank_o(rf_user_bank_o),
        .busy_o(busy_o), .done_o(done_o), .base_wb_we_o(base_wb_we_o),
        .base_wb_o(base_wb_o), .psr_restore_o(psr_restore_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] lst, input bit pre, input bit up, input bit s,
                          input bit wb, input bit ld, input bit canr, input logic [31:0] base,
                          input int waits, input bit poke);
        int q[$];
        int n = 0;
        int beat = 0;
        int wcnt = 0;
        int cyc = 0;
        int last_ack = 0;
        bit finished = 0;
        logic [31:0] first, nbase, exp_addr;
        bit exp_user, exp_rest;
        for (int i = 0; i < 16; i++) if (lst[i]) begin q.push_back(i); n++; end
        case ({pre, up})
            2'b01:   first = base;
            2'b11:   first = base + 32'd4;
            2'b10:   first = base - 32'(4 * n);
            default: first = base - 32'(4 * n) + 32'd4;
        endcase
        nbase    = up ? base + 32'(4 * n) : base - 32'(4 * n);
        exp_user = s && (!ld || !lst[15]);
        exp_rest = s && ld && lst[15] && canr;
        @(negedge clk);
        list_i = lst; pre_i = pre; up_i = up; s_bit_i = s; wb_i = wb;
        load_i = ld; can_restore_i = canr; base_i = base; start_i = 1'b1;
        while (!finished && cyc < 200) begin
            @(negedge clk);
            cyc++;
            start_i = (poke && cyc == 2);
            if (poke && cyc == 2) list_i = 16'h0001;
            mem_ack_i = 1'b0;
            chk(busy_o, "R10 busy during op", 32'(busy_o), 32'd1);
            if (mem_req_o) begin
                if (q.size() == 0) begin
                    chk(0, "R3 extra access", mem_addr_o, 32'd0);
                end else begin
                    exp_addr = first + 32'(4 * beat);
                    chk(mem_addr_o == exp_addr, (beat == 0) ? "R1 first address" : "R2 address step", mem_addr_o, exp_addr);
                    chk(rf_idx_o == 4'(q[0]), "R2 index order", 32'(rf_idx_o), 32'(q[0]));
                    chk(mem_seq_o == (beat != 0), "R8 seq flag", 32'(mem_seq_o), 32'(beat != 0));
                    chk(mem_we_o == !ld, "R12 write dir", 32'(mem_we_o), 32'(!ld));
                    chk(rf_user_bank_o == exp_user, "R5 user bank", 32'(rf_user_bank_o), 32'(exp_user));
                    if (wcnt == waits) begin
                        mem_ack_i = 1'b1;
                        mem_rdata_i = mem[mem_addr_o[9:2]];
                    end else begin
                        wcnt++;
                    end
                end
            end
            #1;
            if (mem_ack_i) begin
                if (ld) begin
                    chk(rf_we_o && rf_wdata_o == mem_rdata_i, "R12 load data", rf_wdata_o, mem_rdata_i);
                    regs[q[0]] = mem_rdata_i;
                end else begin
                    chk(!rf_we_o && mem_wdata_o == regs[q[0]], "R12 store data", mem_wdata_o, regs[q[0]]);
                    mem[mem_addr_o[9:2]] = mem_wdata_o;
                end
                void'(q.pop_front());
                beat++;
                wcnt = 0;
                last_ack = cyc;
            end else if (!mem_req_o) begin
                chk(!rf_we_o, "R12 no stray write", 32'(rf_we_o), 32'd0);
            end
            if (done_o) begin
                finished = 1;
                chk(q.size() == 0 && beat == n, "R3 beat count", 32'(beat), 32'(n));
                if (n == 0) chk(cyc == 1, "R9 empty completes", 32'(cyc), 32'd1);
                else chk(cyc - last_ack == (ld ? 2 : 1), "R7 completion gap", 32'(cyc - last_ack), ld ? 32'd2 : 32'd1);
                chk(base_wb_we_o == wb, "R4 writeback enable", 32'(base_wb_we_o), 32'(wb));
                chk(base_wb_o == nbase, "R4 writeback value", base_wb_o, nbase);
                chk(psr_restore_o == exp_rest, "R6 status restore", 32'(psr_restore_o), 32'(exp_rest));
            end
        end
        mem_ack_i = 1'b0;
        start_i = 1'b0;
        if (!finished) chk(0, "R10 watchdog expired", 32'(cyc), 32'd0);
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R10 idle after done", 32'(busy_o), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + 32'(i * 32'h111);
        for (int j = 0; j < 256; j++) mem[j] = 32'h5000_0000 + 32'(j);
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !done_o && !psr_restore_o, "R10 reset state", 32'(busy_o), 32'd0);
        rst_n = 1'b1;
        run_op(16'h00F1, 0, 1, 0, 1, 0, 0, 32'h0000_0100, 0, 1); // IA store, start ignored while busy
        run_op(16'h8421, 1, 1, 1, 1, 1, 1, 32'h0000_0080, 1, 0); // IB load with restore
        run_op(16'h0306, 1, 0, 1, 1, 0, 1, 32'h0000_0200, 2, 0); // DB store, user bank
        run_op(16'h0030, 0, 0, 1, 0, 1, 1, 32'h0000_0180, 0, 0); // DA load, user bank
        run_op(16'h0000, 0, 1, 0, 1, 1, 0, 32'h0000_0040, 0, 0); // R9 empty list
        run_op(16'hFFFF, 1, 0, 1, 1, 1, 0, 32'h0000_0300, 0, 0); // full DB load, restore blocked
        run_op(16'h0400, 0, 0, 0, 1, 0, 0, 32'h0000_0020, 1, 0); // single DA store
        run_op(16'h8000, 0, 1, 0, 0, 1, 1, 32'h0000_00C0, 3, 0); // IA load of bit 15 only
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule